// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block takes an asynchronous serial line and rebuilds the characters sent on it. A one-cycle enable, `tick`, pulses at sixteen times the bit rate; the block samples the line only on those cycles. The line passes through a two-flop synchronizer first. An idle line sits at 1. A falling edge counts as the start of a character only if the line stays low for half a bit time. The data bits are then sampled near the middle of each bit and shifted in, least significant bit first.

The character width can be 5 to 8 bits. Parity can be off, odd or even. Both settings are run-time inputs, and the block latches them when it sees a candidate start edge. Start, parity and stop bits are removed. Each finished character appears on a byte-wide output with a one-cycle valid strobe. A parity-error flag and a framing-error flag belong to that same character. Only the first stop bit is examined. The receiver then waits at once for the next start edge, so a transmitter using longer stop periods is received without change.

Top module: `uart_rx_os`

## Requirements
- R1: After reset, `rx_valid`, `rx_data`, `par_err` and `frm_err` are all zero.
- R2: A start is accepted only after 8 consecutive tick samples of the synchronized line read 0. A low pulse shorter than that produces no character, and the receiver goes back to waiting for an edge.
- R3: Data bits are sampled every 16 ticks, counting from start acceptance, and arrive least significant bit first. `cfg_bits` sets the count: 00=5, 01=6, 10=7, 11=8.
- R4: For characters shorter than 8 bits, the unused upper bits of `rx_data` are 0.
- R5: `cfg_par` sets parity: 01 is odd and 10 is even. With 00 or 11 there is no parity bit. `par_err` is 1 when the received parity bit and the data ones do not follow the chosen rule, and is always 0 when parity is off.
- R6: `frm_err` is 1 when the first stop bit reads 0 at its sample point.
- R7: `rx_valid` is a single-cycle pulse, one clock after the tick that samples the stop bit. `rx_data`, `par_err` and `frm_err` update only in that cycle and hold until the next character.
- R8: Right after the first stop-bit sample the receiver waits for a new start. Characters sent back to back with one stop bit are all received.
- R9: `cfg_bits` and `cfg_par` are latched at start-edge detection. Changing them during a character does not affect that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable at 16x the bit rate |
| rxd | input | 1 | Asynchronous serial input, idle 1 |
| cfg_bits | input | 2 | Data width code (00=5 .. 11=8) |
| cfg_par | input | 2 | Parity mode (01 odd, 10 even, else none) |
| rx_data | output | 8 | Received character, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for a finished character |
| par_err | output | 1 | Parity error of the current character |
| frm_err | output | 1 | Framing error of the current character |

## Verification
The assertions run on every cycle. They check the following: `rx_valid` is a single-cycle pulse and only follows a tick. The output byte changes only with the strobe. A 5-bit character leaves the upper bits clear. `par_err` stays low when parity is off. The directed scenarios cover the timing-dependent behaviour, which the assertions do not: rejecting short start pulses, LSB-first assembly at every width, correct and corrupted parity in both modes, a low stop bit, back-to-back characters, and a configuration change in the middle of a character.

// File: rtl/uart_rx_os.sv
module uart_rx_os #(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd,
  input  logic [1:0]    cfg_bits,
  input  logic [1:0]    cfg_par,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  output logic          par_err,
  output logic          frm_err
);
  localparam int CW   = $clog2(OSR);
  localparam int HALF = OSR / 2;
  localparam int IW   = $clog2(DW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           st;
  logic [1:0]    sync;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;
  logic [DW-1:0] sh;
  logic [1:0]    bits_q;
  logic [1:0]    par_q;
  logic          acc;
  logic          pe_q;
  logic          rxs;
  logic          last;
  logic          par_on;
  logic [IW-1:0] last_idx;
  logic [DW-1:0] aligned;

  assign rxs      = sync[1];
  assign last     = (cnt == CW'(OSR - 1));
  assign par_on   = par_q[0] ^ par_q[1];
  assign last_idx = IW'(DW - 4) + IW'(bits_q);

  always_comb begin
    case (bits_q)
      2'b00:   aligned = sh >> (DW - 5);
      2'b01:   aligned = sh >> (DW - 6);
      2'b10:   aligned = sh >> (DW - 7);
      default: aligned = sh >> (DW - 8);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sync <= 2'b11;
    else        sync <= {sync[0], rxd};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      bits_q   <= 2'b11;
      par_q    <= 2'b00;
      acc      <= 1'b0;
      pe_q     <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      frm_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tick) begin
        case (st)
          S_IDLE: if (!rxs) begin
            st     <= S_START;
            cnt    <= CW'(1);
            bits_q <= cfg_bits;
            par_q  <= cfg_par;
          end
          S_START: begin
            if (rxs) st <= S_IDLE;
            else if (cnt == CW'(HALF - 1)) begin
              st   <= S_DATA;
              cnt  <= '0;
              idx  <= '0;
              acc  <= 1'b0;
              pe_q <= 1'b0;
            end else cnt <= cnt + 1'b1;
          end
          S_DATA: begin
            if (last) begin
              cnt <= '0;
              sh  <= {rxs, sh[DW-1:1]};
              acc <= acc ^ rxs;
              idx <= idx + 1'b1;
              if (idx == last_idx) st <= par_on ? S_PAR : S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_PAR: begin
            if (last) begin
              cnt  <= '0;
              pe_q <= (acc ^ rxs) != (par_q == 2'b01);
              st   <= S_STOP;
            end else cnt <= cnt + 1'b1;
          end
          S_STOP: begin
            if (last) begin
              cnt      <= '0;
              st       <= S_IDLE;
              rx_valid <= 1'b1;
              rx_data  <= aligned;
              frm_err  <= ~rxs;
              par_err  <= par_on & pe_q;
            end else cnt <= cnt + 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_os_chk.sv
module uart_rx_os_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          par_err,
  input logic [1:0]    bits_q,
  input logic [1:0]    par_q
);
  a_r7_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r7_data_only_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data != $past(rx_data)) |-> rx_valid);

  a_r3_valid_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(tick));

  a_r4_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && bits_q == 2'b00) |-> (rx_data[DW-1:5] == '0));

  a_r5_no_par_err_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (par_q[0] == par_q[1])) |-> !par_err);
endmodule

bind uart_rx_os uart_rx_os_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .rx_valid(rx_valid),
  .rx_data(rx_data), .par_err(par_err), .bits_q(bits_q), .par_q(par_q)
);

// File: tb/test_uart_rx_os.sv
module test_uart_rx_os;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick = 0;
  logic       rxd = 1;
  logic [1:0] cfg_bits = 2'b11;
  logic [1:0] cfg_par = 2'b00;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err;

  int errors = 0, checks = 0, vcnt = 0;
  logic [7:0] cap_d;
  logic cap_pe, cap_fe;
  logic [1:0] tdiv = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 1'b1;
    tick <= (tdiv == 2'd3);
  end

  uart_rx_os i_uart_rx_os (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd),
    .cfg_bits(cfg_bits), .cfg_par(cfg_par), .rx_data(rx_data),
    .rx_valid(rx_valid), .par_err(par_err), .frm_err(frm_err)
  );

  always @(negedge clk) if (rx_valid) begin
    vcnt++;
    cap_d  = rx_data;
    cap_pe = par_err;
    cap_fe = frm_err;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int nticks);
    rxd = v;
    repeat (nticks * 4) @(negedge clk);
  endtask

  // par: 0 none, 1 odd, 2 even
  task automatic send_char(input logic [7:0] d, input int n, input int par,
                           input bit bad_par, input bit stop_ok);
    logic p;
    hold(1'b0, 16);
    for (int i = 0; i < n; i++) hold(d[i], 16);
    if (par != 0) begin
      p = 1'b0;
      for (int i = 0; i < n; i++) p ^= d[i];
      if (par == 1) p = ~p;
      if (bad_par) p = ~p;
      hold(p, 16);
    end
    if (stop_ok) hold(1'b1, 16);
    else begin hold(1'b0, 12); hold(1'b1, 20); end
  endtask

  task automatic expect_char(input string req, input int v0, input logic [7:0] d,
                             input bit pe, input bit fe);
    chk(vcnt == v0 + 1, req, vcnt - v0, 1);
    chk(cap_d == d, req, cap_d, d);
    chk(cap_pe == pe, req, cap_pe, pe);
    chk(cap_fe == fe, req, cap_fe, fe);
  endtask

  task automatic t_reset();
    chk(rx_valid == 0 && rx_data == 0 && par_err == 0 && frm_err == 0,
        "R1", {rx_valid, par_err, frm_err, rx_data}, 0);
  endtask

  task automatic t_basic();
    int v0 = vcnt;
    cfg_bits = 2'b11; cfg_par = 2'b00;
    send_char(8'hA5, 8, 0, 0, 1);
    expect_char("R3", v0, 8'hA5, 0, 0);
    v0 = vcnt;
    send_char(8'h3C, 8, 0, 0, 1);
    expect_char("R3", v0, 8'h3C, 0, 0);
    chk(rx_valid == 0, "R7", rx_valid, 0);
  endtask

  task automatic t_short();
    int v0 = vcnt;
    cfg_bits = 2'b00; cfg_par = 2'b00;
    send_char(8'hF5, 5, 0, 0, 1);
    expect_char("R4", v0, 8'h15, 0, 0);
    v0 = vcnt;
    cfg_bits = 2'b01;
    send_char(8'hFF, 6, 0, 0, 1);
    expect_char("R4", v0, 8'h3F, 0, 0);
  endtask

  task automatic t_parity();
    int v0 = vcnt;
    cfg_bits = 2'b10; cfg_par = 2'b10;
    send_char(8'h55, 7, 2, 0, 1);
    expect_char("R5", v0, 8'h55, 0, 0);
    v0 = vcnt;
    send_char(8'h13, 7, 2, 1, 1);
    expect_char("R5", v0, 8'h13, 1, 0);
    v0 = vcnt;
    cfg_bits = 2'b11; cfg_par = 2'b01;
    send_char(8'hC3, 8, 1, 0, 1);
    expect_char("R5", v0, 8'hC3, 0, 0);
    v0 = vcnt;
    send_char(8'h81, 8, 1, 1, 1);
    expect_char("R5", v0, 8'h81, 1, 0);
    cfg_par = 2'b00;
  endtask

  task automatic t_frame();
    int v0 = vcnt;
    cfg_bits = 2'b11; cfg_par = 2'b00;
    send_char(8'h5A, 8, 0, 0, 0);
    expect_char("R6", v0, 8'h5A, 0, 1);
    v0 = vcnt;
    send_char(8'h96, 8, 0, 0, 1);
    expect_char("R6", v0, 8'h96, 0, 0);
  endtask

  task automatic t_glitch();
    int v0 = vcnt;
    hold(1'b0, 5);
    hold(1'b1, 40);
    chk(vcnt == v0, "R2", vcnt - v0, 0);
    chk(cap_d == 8'h96, "R2", cap_d, 8'h96);
    hold(1'b0, 6);
    hold(1'b1, 40);
    chk(vcnt == v0, "R2", vcnt - v0, 0);
  endtask

  task automatic t_b2b();
    int v0 = vcnt;
    logic [7:0] d1;
    cfg_bits = 2'b11; cfg_par = 2'b00;
    send_char(8'h11, 8, 0, 0, 1);
    d1 = cap_d;
    send_char(8'hEE, 8, 0, 0, 1);
    chk(vcnt == v0 + 2, "R8", vcnt - v0, 2);
    chk(d1 == 8'h11, "R8", d1, 8'h11);
    chk(cap_d == 8'hEE, "R8", cap_d, 8'hEE);
  endtask

  task automatic t_cfg_change();
    int v0 = vcnt;
    cfg_bits = 2'b11; cfg_par = 2'b00;
    fork
      send_char(8'hB7, 8, 0, 0, 1);
      begin
        repeat (40 * 4) @(negedge clk);
        cfg_bits = 2'b00; cfg_par = 2'b10;
      end
    join
    expect_char("R9", v0, 8'hB7, 0, 0);
    cfg_bits = 2'b11; cfg_par = 2'b00;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    hold(1'b1, 4);
    t_basic();
    t_short();
    t_parity();
    t_frame();
    t_glitch();
    t_b2b();
    t_cfg_change();
    done = 1;
    finish_run();
  end
endmodule